// File: doc/BRIEF.md
# Variable-Length Instruction Length Predecoder

This block sits beside an instruction fetch path and watches a byte stream of variable-length instructions, one byte per cycle under a valid qualifier. It tracks where each instruction begins and how many bytes it spans. For every accepted byte it reports, one cycle later, whether that byte opened an instruction, whether it closed one, and, on the byte where the total length first becomes known, that length in bytes together with a flag for encodings it does not recognise.

Most lengths follow from the first byte alone, through ranges and single codes. A per-byte context input marks a first byte as an addressing-mode code rather than an opcode. One mode code is followed by a qualifier byte whose low bits settle the final length, so for that case the length is reported on the second byte. Unrecognised first bytes count as one byte long so that the boundary tracking never loses alignment.

Top module: `insn_len_predec`

## Requirements
- R1: A synchronous active-high reset clears all outputs and abandons any partly seen instruction; the next accepted byte is treated as a first byte.
- R2: In opcode context the first bytes 00, 02, 03, 05, 07, 0C, 0D, 0E, 10 to 16, 18, 19, 28 to 2F, 38 to 3F, 48 to 4F, 58 to 5F and F8 to FF are reported with length 1.
- R3: In opcode context the first bytes 06, 09, 17, 20 to 27 and 60 to 6F are reported with length 2.
- R4: In opcode context the first bytes 08, 0B, 0F, 1A, 1C, 1E, 30 to 37 and 70 to 7F are reported with length 3.
- R5: In opcode context the first bytes 0A, 1B and 1D are reported with length 4, and 40 to 47 with length 5.
- R6: Any other opcode first byte raises the unknown flag and is reported with length 1.
- R7: Each output appears exactly one cycle after its byte is accepted; o_valid follows in_valid with that delay, every other flag is low while o_valid is low, and cycles without in_valid do not advance the instruction.
- R8: o_last is high for the final byte of each instruction and only then; the byte after it always carries o_start.
- R9: With in_mode high on a first byte, codes 00 to 07 give length 1, 08 to 0F give 2, 10, 11 and 12 give 2, 3 and 4, 14 and 15 give 2, and any code other than 13 is unknown with length 1; in_mode on a non-first byte has no effect.
- R10: Mode code 13 reports start without a length; the following qualifier byte reports the length: low bits 00 give 2, 01 give 4, 11 give 4 whatever bit 2 holds, and 10 gives 2 with the unknown flag.
- R11: o_len_valid is high exactly once per instruction, with o_len between 1 and 5: on the first byte, or on the qualifier byte for mode code 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Stream byte |
| in_mode | input | 1 | First byte is an addressing-mode code, not an opcode |
| o_valid | output | 1 | Report for the byte accepted in the previous cycle |
| o_start | output | 1 | That byte began an instruction |
| o_last | output | 1 | That byte ended an instruction |
| o_len_valid | output | 1 | o_len carries the instruction length |
| o_len | output | LEN_W | Total instruction length in bytes |
| o_unknown | output | 1 | Encoding not recognised (length taken as given) |

## Verification
Every one of the 256 byte values is fed as a first byte in both contexts, each followed by just enough filler bytes, which separates the length classes and exposes any range edge placed one code off. The qualifier byte is walked through all four low-bit patterns with bit 2 both clear and set, showing that only bits 1:0 matter. Streams with gaps, a context bit raised on a trailing byte and a reset in the middle of an instruction tell apart correct boundary tracking from a counter that drifts or advances on idle cycles. A long pseudo-random stream mixing both contexts and gaps is compared against the behavioural model on every cycle.

// File: rtl/insn_len_predec.sv
module insn_len_predec #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_mode,
  output logic             o_valid,
  output logic             o_start,
  output logic             o_last,
  output logic             o_len_valid,
  output logic [LEN_W-1:0] o_len,
  output logic             o_unknown
);

  localparam logic [LEN_W-1:0] L0 = LEN_W'(0);
  localparam logic [LEN_W-1:0] L1 = LEN_W'(1);
  localparam logic [LEN_W-1:0] L2 = LEN_W'(2);
  localparam logic [LEN_W-1:0] L3 = LEN_W'(3);
  localparam logic [LEN_W-1:0] L4 = LEN_W'(4);
  localparam logic [LEN_W-1:0] L5 = LEN_W'(5);

  logic [LEN_W-1:0] rem_q;
  logic             qual_q;

  logic [LEN_W-1:0] op_len, md_len, q_len, first_len;
  logic             op_unk, md_unk, md_qual, q_unk, first_unk;

  always_comb begin
    op_len = L1;
    op_unk = 1'b0;
    if (in_byte inside {8'h00, 8'h02, 8'h03, 8'h05, 8'h07, 8'h0C, 8'h0D, 8'h0E,
                        [8'h10:8'h16], 8'h18, 8'h19, [8'h28:8'h2F], [8'h38:8'h3F],
                        [8'h48:8'h4F], [8'h58:8'h5F], [8'hF8:8'hFF]})
      op_len = L1;
    else if (in_byte inside {8'h06, 8'h09, 8'h17, [8'h20:8'h27], [8'h60:8'h6F]})
      op_len = L2;
    else if (in_byte inside {8'h08, 8'h0B, 8'h0F, 8'h1A, 8'h1C, 8'h1E,
                             [8'h30:8'h37], [8'h70:8'h7F]})
      op_len = L3;
    else if (in_byte inside {8'h0A, 8'h1B, 8'h1D})
      op_len = L4;
    else if (in_byte inside {[8'h40:8'h47]})
      op_len = L5;
    else
      op_unk = 1'b1;
  end

  always_comb begin
    md_len  = L1;
    md_unk  = 1'b0;
    md_qual = 1'b0;
    case (in_byte) inside
      [8'h00:8'h07]:                 md_len = L1;
      [8'h08:8'h0F], 8'h10:          md_len = L2;
      8'h11:                         md_len = L3;
      8'h12:                         md_len = L4;
      8'h13:                         md_qual = 1'b1;
      8'h14, 8'h15:                  md_len = L2;
      default:                       md_unk = 1'b1;
    endcase
  end

  assign q_len     = in_byte[0] ? L4 : L2;
  assign q_unk     = (in_byte[1:0] == 2'b10);
  assign first_len = in_mode ? md_len : op_len;
  assign first_unk = in_mode ? md_unk : op_unk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q       <= L0;
      qual_q      <= 1'b0;
      o_valid     <= 1'b0;
      o_start     <= 1'b0;
      o_last      <= 1'b0;
      o_len_valid <= 1'b0;
      o_len       <= L0;
      o_unknown   <= 1'b0;
    end else begin
      o_valid     <= in_valid;
      o_start     <= 1'b0;
      o_last      <= 1'b0;
      o_len_valid <= 1'b0;
      o_len       <= L0;
      o_unknown   <= 1'b0;
      if (in_valid) begin
        if (qual_q) begin
          qual_q      <= 1'b0;
          o_len_valid <= 1'b1;
          o_len       <= q_len;
          o_unknown   <= q_unk;
          o_last      <= (q_len == L2);
          rem_q       <= q_len - L2;
        end else if (rem_q != L0) begin
          rem_q  <= rem_q - L1;
          o_last <= (rem_q == L1);
        end else begin
          o_start <= 1'b1;
          if (in_mode && md_qual) begin
            qual_q <= 1'b1;
          end else begin
            o_len_valid <= 1'b1;
            o_len       <= first_len;
            o_unknown   <= first_unk;
            o_last      <= (first_len == L1);
            rem_q       <= first_len - L1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/insn_len_predec_chk.sv
module insn_len_predec_chk #(
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             o_valid,
  input logic             o_start,
  input logic             o_last,
  input logic             o_len_valid,
  input logic [LEN_W-1:0] o_len,
  input logic             o_unknown
);

  logic at_bnd;
  logic len_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_bnd   <= 1'b1;
      len_seen <= 1'b0;
    end else if (o_valid) begin
      at_bnd   <= o_last;
      len_seen <= o_last ? 1'b0 : (len_seen | o_len_valid);
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !o_valid); // R7
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> !(o_start || o_last || o_len_valid || o_unknown)); // R7
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    o_len_valid |-> (o_len >= LEN_W'(1) && o_len <= LEN_W'(5))); // R11
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (o_len_valid && o_start && o_len == LEN_W'(1)) |-> o_last); // R8
  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_start == at_bnd)); // R8
  AST_LEN_ONCE: assert property (@(posedge clk) disable iff (rst)
    o_len_valid |-> !len_seen); // R11
  AST_LEN_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
    o_last |-> (len_seen || o_len_valid)); // R11

endmodule

bind insn_len_predec insn_len_predec_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .o_valid(o_valid),
  .o_start(o_start), .o_last(o_last), .o_len_valid(o_len_valid),
  .o_len(o_len), .o_unknown(o_unknown)
);

// File: tb/test_insn_len_predec.sv
`timescale 1ns/1ps
module test_insn_len_predec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_mode = 1'b0;
  logic       o_valid, o_start, o_last, o_len_valid, o_unknown;
  logic [2:0] o_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int  m_rem  = 0;
  bit  m_qual = 1'b0;

  always #2.5 clk = ~clk;

  insn_len_predec i_insn_len_predec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_mode(in_mode),
    .o_valid(o_valid), .o_start(o_start), .o_last(o_last),
    .o_len_valid(o_len_valid), .o_len(o_len), .o_unknown(o_unknown)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_opcode(input int x, output int len, output bit unk, output string tag);
    unk = 1'b0;
    if ((x >= 'h28 && x <= 'h2F) || (x >= 'h38 && x <= 'h3F) || (x >= 'h48 && x <= 'h4F) ||
        (x >= 'h58 && x <= 'h5F) || x >= 'hF8 || (x >= 'h10 && x <= 'h16) ||
        x == 'h00 || x == 'h02 || x == 'h03 || x == 'h05 || x == 'h07 ||
        x == 'h0C || x == 'h0D || x == 'h0E || x == 'h18 || x == 'h19) begin
      len = 1; tag = "R2";
    end else if ((x >= 'h60 && x <= 'h6F) || (x >= 'h20 && x <= 'h27) ||
                 x == 'h06 || x == 'h09 || x == 'h17) begin
      len = 2; tag = "R3";
    end else if ((x >= 'h70 && x <= 'h7F) || (x >= 'h30 && x <= 'h37) || x == 'h08 ||
                 x == 'h0B || x == 'h0F || x == 'h1A || x == 'h1C || x == 'h1E) begin
      len = 3; tag = "R4";
    end else if (x == 'h0A || x == 'h1B || x == 'h1D || (x >= 'h40 && x <= 'h47)) begin
      len = (x >= 'h40) ? 5 : 4; tag = "R5";
    end else begin
      len = 1; unk = 1'b1; tag = "R6";
    end
  endfunction

  function automatic void ref_mode(input int x, output int len, output bit unk, output bit q);
    unk = 1'b0; q = 1'b0;
    if (x < 8) len = 1;
    else if (x < 16) len = 2;
    else if (x == 'h10 || x == 'h14 || x == 'h15) len = 2;
    else if (x == 'h11) len = 3;
    else if (x == 'h12) len = 4;
    else if (x == 'h13) begin len = 0; q = 1'b1; end
    else begin len = 1; unk = 1'b1; end
  endfunction

  // drive one cycle, compute expectation, compare after the clock edge
  task automatic step(input bit v, input logic [7:0] b, input bit m);
    bit e_start = 0, e_last = 0, e_lv = 0, e_unk = 0, q = 0;
    int e_len = 0;
    string tag = "R7";
    @(negedge clk);
    in_valid = v; in_byte = b; in_mode = m;
    if (v) begin
      if (m_qual) begin
        tag = "R10";
        m_qual = 1'b0;
        e_lv = 1; e_len = b[0] ? 4 : 2; e_unk = (b[1:0] == 2'b10);
        e_last = (e_len == 2); m_rem = e_len - 2;
      end else if (m_rem > 0) begin
        tag = m ? "R9" : "R8";
        m_rem--; e_last = (m_rem == 0);
      end else begin
        e_start = 1;
        if (m) begin
          tag = "R9";
          ref_mode(b, e_len, e_unk, q);
          if (q) begin m_qual = 1'b1; tag = "R10"; end
        end else ref_opcode(b, e_len, e_unk, tag);
        if (!q) begin e_lv = 1; e_last = (e_len == 1); m_rem = e_len - 1; end
      end
    end
    @(negedge clk);
    chk("R7", "o_valid", o_valid, v);
    chk("R8", "o_start", o_start, e_start);
    chk("R8", "o_last", o_last, e_last);
    chk("R11", "o_len_valid", o_len_valid, e_lv);
    if (e_lv) chk(tag, "o_len", o_len, e_len);
    chk(tag, "o_unknown", o_unknown, e_unk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_byte = 8'h40;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    m_rem = 0; m_qual = 1'b0;
    chk("R1", "o_valid", o_valid, 0);
    chk("R1", "o_start", o_start, 0);
    chk("R1", "o_len_valid", o_len_valid, 0);
  endtask

  task automatic drain(input logic [7:0] f);
    while (m_rem > 0 || m_qual) step(1, f, 0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    // R1: reset mid-instruction, next byte is a first byte
    step(1, 8'h40, 0); step(1, 8'h11, 0);
    do_reset();
    step(1, 8'h00, 0);
    // R7: gaps inside an instruction
    step(1, 8'h1B, 0); step(0, 8'h00, 0); step(1, 8'h22, 0); step(0, 8'h00, 0);
    step(1, 8'h33, 0); step(1, 8'h44, 0);
    // R9: mode bit on trailing bytes is ignored
    step(1, 8'h30, 0); step(1, 8'h13, 1); step(1, 8'h12, 1);
    // R10: all qualifier patterns, bit 2 both ways
    for (int qv = 0; qv < 8; qv++) begin
      step(1, 8'h13, 1); step(1, 8'(8'hF0 | qv), 0); drain(8'h13);
    end
    // sweep every first byte in both contexts
    for (int i = 0; i < 256; i++) begin step(1, 8'(i), 0); drain(8'(i ^ 8'h5A)); end
    for (int i = 0; i < 256; i++) begin step(1, 8'(i), 1); drain(8'(i ^ 8'hA5)); end
    // mixed pseudo-random stream
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'h0, lfsr[15:8], lfsr[4] & lfsr[6]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule